// File: doc/BRIEF.md
# Serial Line Datapath with Loopback Steering

This block is the digital path between an 8-bit parallel framer port and a single-bit serial line, all clocked by the bit clock. On the transmit side, a parallel byte is captured once per word and shifted out most significant bit first. On the receive side, incoming line bits are gathered most significant bit first and handed out as a byte once per word. An internal divide-by-8 counter marks the word boundaries and drives a parallel clock-enable output that the framer side uses to qualify the parallel buses.

Three loopback controls steer the paths for diagnostics. Line echo returns received line bits to the serial output after a fixed two-clock delay, and the parallel receive side keeps working. Parallel wrap hands the transmit byte straight to the receive byte, and the serial output keeps working. Serializer wrap feeds the serialized transmit stream back into the deserializer. Line echo and parallel wrap may be combined. When serializer wrap is set, it owns the receive path. Mode inputs are sampled only at word boundaries, so a mode change never produces a partial word.

Top module: `serdes_lb_path`

## Requirements
- R1: With line echo off, the byte on `tx_byte_i` at a boundary edge (an edge where `word_stb_o` is high) is shifted out most significant bit first on `tx_bit_o`. Bit 7 appears after the first edge following the boundary, and bit 0 after the eighth.
- R2: With no loopback active on the receive path, `rx_byte_o` updated at a boundary edge holds the `rx_bit_i` values sampled at the eight preceding edges. The earliest of these edges gives bit 7, and the edge just before the boundary gives bit 0.
- R3: `word_stb_o` is high for exactly one clock in every 8, first before the eighth edge after reset release. `rx_byte_o` changes only at boundary edges.
- R4: With line echo active (`lb_rem_i`), `tx_bit_o` after edge n equals `rx_bit_i` sampled at edge n-1, so the delay is two bit clocks. `tx_byte_i` has no effect on the serial output, and the receive byte still follows R2.
- R5: With parallel wrap active (`lb_dig_i`) and serializer wrap inactive, `rx_byte_o` at a boundary edge equals `tx_byte_i` at that edge. `rx_bit_i` is ignored, and the serial output still follows R1.
- R6: With serializer wrap active (`lb_ana_i`), `rx_byte_o` at a boundary edge equals the byte loaded at the previous boundary. `rx_bit_i` is ignored.
- R7: Line echo and parallel wrap together act as a dual loopback: the serial output follows R4 and the receive byte follows R5.
- R8: Serializer wrap takes priority over parallel wrap and line echo for the receive byte. Line echo still controls the serial output.
- R9: The three mode inputs are sampled at boundary edges only. A mode sampled at boundary S governs the serial output for edges S+1 to S+8 and the receive byte captured at S+8.
- R10: While `rst_ni` is low, `tx_bit_o`, `rx_byte_o` and `word_stb_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_byte_i | input | 8 | Parallel transmit byte, sampled at boundary edges |
| rx_bit_i | input | 1 | Received line bit |
| lb_rem_i | input | 1 | Line echo enable |
| lb_dig_i | input | 1 | Parallel wrap enable |
| lb_ana_i | input | 1 | Serializer wrap enable |
| tx_bit_o | output | 1 | Serial transmit bit |
| rx_byte_o | output | 8 | Parallel receive byte |
| word_stb_o | output | 1 | Parallel clock enable; the next edge is a word boundary |

## Verification
The echo-delay and parallel-wrap properties assume that the mode they check was latched at a boundary, so they key on the latched mode rather than on the raw mode pins. This leaves the pins free to change mid-word. The stimulus changes modes deliberately in the middle of a word and walks through all eight mode combinations, so every property fires only after a boundary has sampled the new mode. Line bits come from a free-running pseudo-random sequence that runs even while they should be ignored, and transmit bytes include all-zero, all-one and single-bit values. This exposes bit-order and ignore errors.

// File: rtl/serdes_lb_pkg.sv
package serdes_lb_pkg;

  typedef struct packed {
    logic ana;
    logic dig;
    logic rem;
  } lb_mode_t;

  typedef enum logic [1:0] {
    RX_SRC_LINE = 2'd0,
    RX_SRC_PAR  = 2'd1,
    RX_SRC_SER  = 2'd2
  } rx_src_e;

  // serializer wrap owns the receive path, then parallel wrap
  function automatic rx_src_e rx_pick(lb_mode_t m);
    if (m.ana)      return RX_SRC_SER;
    else if (m.dig) return RX_SRC_PAR;
    else            return RX_SRC_LINE;
  endfunction

endpackage

// File: rtl/lb_word_timer.sv
module lb_word_timer #(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic stb_o
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt_q;

  assign stb_o = (cnt_q == CW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (stb_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lb_piso.sv
module lb_piso #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  assign bit_o = sh_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= data_i;
    else             sh_q <= {sh_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/lb_sipo.sv
module lb_sipo #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-2:0] sh_q;

  // word includes the bit being sampled at this edge
  assign word_o = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[W-3:0], bit_i};
  end
endmodule

// File: rtl/serdes_lb_path.sv
module serdes_lb_path
  import serdes_lb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] tx_byte_i,
  input  logic         rx_bit_i,
  input  logic         lb_rem_i,
  input  logic         lb_dig_i,
  input  logic         lb_ana_i,
  output logic         tx_bit_o,
  output logic [W-1:0] rx_byte_o,
  output logic         word_stb_o
);
  logic         stb;
  logic         ser_bit;
  logic         rx_q;
  logic         tx_q;
  logic         des_bit;
  logic [W-1:0] des_word;
  logic [W-1:0] rx_byte_q;
  lb_mode_t     mode_q;
  rx_src_e      rx_src;

  lb_word_timer #(.W(W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_o (stb)
  );

  lb_piso #(.W(W)) u_piso (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(stb),
    .data_i(tx_byte_i),
    .bit_o (ser_bit)
  );

  assign rx_src  = rx_pick(mode_q);
  assign des_bit = (rx_src == RX_SRC_SER) ? ser_bit : rx_q;

  lb_sipo #(.W(W)) u_sipo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (des_bit),
    .word_o(des_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      rx_q      <= 1'b0;
      tx_q      <= 1'b0;
      rx_byte_q <= '0;
    end else begin
      rx_q <= rx_bit_i;
      tx_q <= mode_q.rem ? rx_q : ser_bit;
      if (stb) begin
        rx_byte_q <= (rx_src == RX_SRC_PAR) ? tx_byte_i : des_word;
        mode_q    <= '{ana: lb_ana_i, dig: lb_dig_i, rem: lb_rem_i};
      end
    end
  end

  assign tx_bit_o   = tx_q;
  assign rx_byte_o  = rx_byte_q;
  assign word_stb_o = stb;
endmodule

// File: rtl/serdes_lb_path_chk.sv
module serdes_lb_path_chk
  import serdes_lb_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] tx_byte_i,
  input logic         rx_bit_i,
  input logic         tx_bit_o,
  input logic [W-1:0] rx_byte_o,
  input logic         word_stb_o,
  input lb_mode_t     mode_q
);
  localparam int GW = $clog2(W) + 1;

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gap_q <= '0;
    else if (word_stb_o) gap_q <= '0;
    else                 gap_q <= gap_q + 1'b1;
  end

  p_stb_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |=> !word_stb_o);

  p_stb_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < GW'(W));

  p_rx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_stb_o |=> $stable(rx_byte_o));

  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_stb_o |=> $stable(mode_q));

  p_echo_delay_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.rem |=> (tx_bit_o == $past(rx_bit_i, 2)));

  p_par_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_stb_o && mode_q.dig && !mode_q.ana) |=> (rx_byte_o == $past(tx_byte_i)));
endmodule

bind serdes_lb_path serdes_lb_path_chk #(.W(W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_byte_i (tx_byte_i),
  .rx_bit_i  (rx_bit_i),
  .tx_bit_o  (tx_bit_o),
  .rx_byte_o (rx_byte_o),
  .word_stb_o(word_stb_o),
  .mode_q    (mode_q)
);

// File: tb/serdes_lb_path_tb_top.sv
module serdes_lb_path_tb_top;
  localparam int NE = 1400;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] tx_byte_i;
  logic       rx_bit_i;
  logic       lb_rem_i, lb_dig_i, lb_ana_i;
  logic       tx_bit_o;
  logic [7:0] rx_byte_o;
  logic       word_stb_o;

  always #5 clk_i = ~clk_i;

  serdes_lb_path #(.W(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_byte_i(tx_byte_i), .rx_bit_i(rx_bit_i),
    .lb_rem_i(lb_rem_i), .lb_dig_i(lb_dig_i), .lb_ana_i(lb_ana_i),
    .tx_bit_o(tx_bit_o), .rx_byte_o(rx_byte_o), .word_stb_o(word_stb_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int n      = 0;

  bit       bnd_l [NE];
  bit       txo_l [NE];
  bit       rxin_l[NE];
  bit [7:0] rxb_l [NE];
  bit [7:0] txin_l[NE];
  bit [2:0] md_l  [NE];   // {ana,dig,rem}

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // log pre-edge inputs, step one edge, log post-edge outputs
  task automatic tick();
    bnd_l[n]  = word_stb_o;
    txin_l[n] = tx_byte_i;
    rxin_l[n] = rx_bit_i;
    md_l[n]   = {lb_ana_i, lb_dig_i, lb_rem_i};
    @(posedge clk_i);
    #1;
    txo_l[n] = tx_bit_o;
    rxb_l[n] = rx_byte_o;
    n++;
  endtask

  function automatic logic [7:0] byte_pat(int w);
    case (w % 12)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h80;
      3: return 8'h01;
      default: return 8'((w * 37 + 11) & 8'hFF);
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_ni = 1'b0;
    tx_byte_i = 8'h00; rx_bit_i = 1'b0;
    lb_rem_i = 1'b0; lb_dig_i = 1'b0; lb_ana_i = 1'b0;
    lfsr = 16'hACE1;
    #13;
    tx_byte_i = 8'h5A; rx_bit_i = 1'b1;
    #4;
    chk(tx_bit_o == 1'b0 && rx_byte_o == 8'h00 && word_stb_o == 1'b0, "R10 reset outputs",
        {tx_bit_o, rx_byte_o, word_stb_o}, 0);
    #6;
    rst_ni = 1'b1;

    // two sweeps of eight mode combos, four words each, mode changed mid-word
    for (int c = 0; c < 16 * 4 * 8 + 24; c++) begin
      int w;
      w = c / 8;
      tx_byte_i = byte_pat(w);
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rx_bit_i  = lfsr[0];
      if ((c % 32) == 3) begin
        int combo;
        combo = (c / 32) % 8;
        lb_rem_i = combo[0];
        lb_dig_i = combo[1];
        lb_ana_i = combo[2];
      end
      tick();
    end

    // first strobe placement
    begin
      bit ok;
      ok = bnd_l[7];
      for (int i = 0; i < 7; i++) if (bnd_l[i]) ok = 1'b0;
      chk(ok, "R3 first strobe before edge 7", 32'(ok), 1);
    end

    for (int s = 15; s + 16 < n; s++) begin
      if (bnd_l[s]) begin
        bit rem, dig, ana, chg, ok3;
        logic [7:0] act, exp;
        string tg;
        rem = md_l[s][0]; dig = md_l[s][1]; ana = md_l[s][2];
        chg = (md_l[s] != md_l[s-8]);

        for (int i = 0; i < 8; i++) begin
          act[7-i] = txo_l[s+1+i];
          exp[7-i] = rem ? rxin_l[s+i] : txin_l[s][7-i];
        end
        tg = rem ? (dig ? "R7 tx dual" : "R4 tx echo") :
             (ana ? "R6 tx serwrap" : (dig ? "R5 tx parwrap" : "R1 tx serialize"));
        if (chg) tg = {tg, " R9"};
        chk(act == exp, tg, act, exp);

        if (ana)      exp = txin_l[s];
        else if (dig) exp = txin_l[s+8];
        else for (int i = 0; i < 8; i++) exp[7-i] = rxin_l[s+i];
        act = rxb_l[s+8];
        tg = ana ? ((dig || rem) ? "R8 rx priority" : "R6 rx serwrap") :
             dig ? (rem ? "R7 rx dual" : "R5 rx parwrap") :
             (rem ? "R4 rx kept" : "R2 rx assemble");
        if (chg) tg = {tg, " R9"};
        chk(act == exp, tg, act, exp);

        ok3 = bnd_l[s+8];
        for (int i = 1; i < 8; i++) begin
          if (bnd_l[s+i]) ok3 = 1'b0;
          if (rxb_l[s+8+i] != rxb_l[s+8]) ok3 = 1'b0;
        end
        chk(ok3, "R3 strobe period and rx hold", 32'(ok3), 1);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule